// File: doc/BRIEF.md
# Counted-Delay Wait Controller

This block implements a timed pause as a cycle count rather than a time value. The surrounding logic picks a cycle count `n` that suits its clock rate and pulses `start`. The controller then runs a fixed sequence. One preset cycle loads an internal down-counter. A wait phase follows, which repeats until the counter is empty. The block then gives a single-cycle strobe that tells the next stage to proceed.

From the cycle in which the preset state is entered to the cycle in which the strobe appears, exactly `n+2` clock cycles pass. This holds for every `n`, including zero. The counter enable and count-down controls are brought out, so a monitor can follow what the datapath is doing in each cycle. All outputs come from registers. Reset is synchronous and active high.

Top module: `dly_wait_timer`

## Requirements
- R1: A synchronous reset, applied at any point in the sequence, drives `busy`, `go_next`, `cnt_en` and `cnt_dn` low from the next cycle onward and returns the block to idle with its counter cleared. A start given after reset then produces a correct sequence.
- R2: A `start` sampled high while idle makes the following cycle a preset cycle, in which `busy`=1, `cnt_en`=1, `cnt_dn`=0 and `go_next`=0.
- R3: `delay_n` is captured on the clock edge that accepts `start`. Any later change to `delay_n` has no effect on the sequence in progress.
- R4: After the preset cycle, `cnt_en` and `cnt_dn` are both high for exactly `n` consecutive cycles. One further cycle follows with both low and `busy` still high.
- R5: `go_next` is high in the cycle that begins `n+2` cycles after the preset cycle begins. `busy` is high for exactly those `n+2` cycles.
- R6: `go_next` is high for exactly one cycle, with `busy` low in that cycle. The block is idle in the cycle after it, with all outputs low.
- R7: With `n`=0 the sequence takes 2 busy cycles, and `cnt_dn` is never asserted.
- R8: `start` is accepted only while idle. If it is high during the busy cycles or during the strobe cycle, it is ignored.
- R9: `cnt_dn` is never high unless `cnt_en` is also high, and the counter is never decremented while it holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a counted wait |
| delay_n | input | 16 | Wait length in cycles, captured when start is accepted |
| busy | output | 1 | High from the preset cycle through the last wait cycle |
| go_next | output | 1 | One-cycle strobe: the wait is over |
| cnt_en | output | 1 | Counter enable (preset or decrement) |
| cnt_dn | output | 1 | Counter decrement select |

## Verification
The hardest case to reach from the ports is a start pulse or a new `delay_n` that arrives while a sequence is already running, and in particular one that lands exactly on the strobe cycle. Both would silently stretch or restart a wait without being obvious. The stimulus drives random start levels and random `delay_n` values during every busy cycle and during the strobe cycle, and then checks the exact cycle-by-cycle output pattern. A reset applied in the middle of a long wait is followed by a short sequence that must come out exact, which shows that no stale count survived the reset.

// File: rtl/dly_wait_pkg.sv
package dly_wait_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_WAIT = 2'd2,
    ST_NEXT = 2'd3
  } dly_state_e;
endpackage

// File: rtl/dly_counter.sv
module dly_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap,
  input  logic [CNT_W-1:0] cap_val,
  input  logic             load,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] hold_q;

  // Count captured when a request is accepted; the preset cycle copies it.
  always_ff @(posedge clk) begin
    if (rst)      hold_q <= '0;
    else if (cap) hold_q <= cap_val;
  end

  always_comb begin
    if (load)     cnt_nxt = hold_q;
    else if (dec) cnt_nxt = cnt_q - ONE;
    else          cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  // R9: the decrement is never issued against an empty counter
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
    dec |-> (cnt_q != '0));

  // R3: the captured count only changes on a capture
  p_hold_kept_r3: assert property (@(posedge clk) disable iff (rst)
    (!cap && !$past(rst)) |=> $stable(hold_q));
endmodule

// File: rtl/dly_fsm.sv
module dly_fsm
  import dly_wait_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic             cap,
  output logic             busy,
  output logic             go_next,
  output logic             cnt_en,
  output logic             cnt_dn
);
  dly_state_e st_q, st_d;
  logic       cnt_zero;
  logic       nxt_nonzero;

  assign cnt_zero    = (cnt_q == '0);
  assign nxt_nonzero = (cnt_nxt != '0);
  assign cap         = start && (st_q == ST_IDLE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_LOAD;
      ST_LOAD: st_d = ST_WAIT;
      ST_WAIT: if (cnt_zero) st_d = ST_NEXT;
      ST_NEXT: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // Outputs registered from the next state and next count so they line up
  // with the state they describe.
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      busy    <= 1'b0;
      go_next <= 1'b0;
      cnt_en  <= 1'b0;
      cnt_dn  <= 1'b0;
    end else begin
      st_q    <= st_d;
      busy    <= (st_d == ST_LOAD) || (st_d == ST_WAIT);
      go_next <= (st_d == ST_NEXT);
      cnt_en  <= (st_d == ST_LOAD) || ((st_d == ST_WAIT) && nxt_nonzero);
      cnt_dn  <= (st_d == ST_WAIT) && nxt_nonzero;
    end
  end

  p_load_then_wait_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_LOAD) |=> (st_q == ST_WAIT && busy));

  p_wait_exit_r5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT && cnt_zero) |=> go_next);

  p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
    go_next |=> (!go_next && !busy));

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE) |=> (st_q != ST_LOAD));

  p_dn_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_dn |-> cnt_en);

  p_busy_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(busy && go_next));
endmodule

// File: rtl/dly_wait_timer.sv
module dly_wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] delay_n,
  output logic             busy,
  output logic             go_next,
  output logic             cnt_en,
  output logic             cnt_dn
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             cap;
  logic             do_load, do_dec;

  assign do_load = cnt_en && !cnt_dn;
  assign do_dec  = cnt_en && cnt_dn;

  dly_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt),
    .cap     (cap),
    .busy    (busy),
    .go_next (go_next),
    .cnt_en  (cnt_en),
    .cnt_dn  (cnt_dn)
  );

  dly_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .cap     (cap),
    .cap_val (delay_n),
    .load    (do_load),
    .dec     (do_dec),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt)
  );

  // R1: the first cycle after reset shows every output low
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(busy || go_next || cnt_en || cnt_dn));
endmodule

// File: tb/tb_dly_wait_timer.sv
module tb_dly_wait_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] delay_n = '0;
  logic        busy, go_next, cnt_en, cnt_dn;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  always #4 clk = ~clk;

  dly_wait_timer #(.CNT_W(16)) dut (
    .clk(clk), .rst(rst), .start(start), .delay_n(delay_n),
    .busy(busy), .go_next(go_next), .cnt_en(cnt_en), .cnt_dn(cnt_dn)
  );

  // Expected {busy, go_next, cnt_en, cnt_dn} for cycle i, where cycle 0 is preset
  function automatic logic [3:0] expect_at(int i, int n);
    if (i == 0)           return 4'b1010;
    else if (i <= n)      return 4'b1011;
    else if (i == n + 1)  return 4'b1000;
    else if (i == n + 2)  return 4'b0100;
    else                  return 4'b0000;
  endfunction

  function automatic string tag_for(int i, int n);
    if (i == 0)           return "R2";
    else if (i <= n)      return (n == 0) ? "R7" : "R4";
    else if (i == n + 1)  return "R4";
    else if (i == n + 2)  return "R5";
    else                  return "R6";
  endfunction

  task automatic check(string req, logic [3:0] exp);
    logic [3:0] act;
    act = {busy, go_next, cnt_en, cnt_dn};
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs {busy,go_next,cnt_en,cnt_dn} actual %b expected %b", req, act, exp);
    end
  endtask

  // Run one sequence; with noise, start and delay_n are scrambled while busy (R3, R8)
  task automatic run_seq(int n, bit noise);
    @(negedge clk);
    delay_n = 16'(n);
    start   = 1'b1;
    @(negedge clk);
    for (int i = 0; i <= n + 3; i++) begin
      check(tag_for(i, n), expect_at(i, n));
      if (noise) begin
        delay_n = 16'($urandom);
        start   = (i < n + 3) ? 1'($urandom) : 1'b0;
        if (i == n + 2) start = 1'b1; // R8: start on the strobe cycle is ignored
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    check("R1", 4'b0000);
    rst = 1'b0;
    @(negedge clk);
    check("R1", 4'b0000);

    // Directed corners
    run_seq(0, 1'b0);   // R7
    run_seq(0, 1'b1);   // R7, R8
    run_seq(1, 1'b0);
    run_seq(2, 1'b1);   // R3
    run_seq(300, 1'b1); // R5 long wait

    // Reset in the middle of a wait (R1)
    @(negedge clk);
    delay_n = 16'd50;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1", 4'b0000);
    @(negedge clk);
    check("R1", 4'b0000);
    run_seq(3, 1'b0);   // R1: fresh count after reset

    // Constrained random lengths, mixed noise
    for (int k = 0; k < 60; k++) begin
      run_seq(int'($urandom_range(0, 40)), 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule